// File: doc/BRIEF.md
# Predictive Control Playback Buffer

This block sits at the actuator end of a wireless control loop. The controller sends one frame per sample period. Each frame carries the control value for the current period, followed by a forecast of the next HORIZON control values. Frame words arrive one per cycle. The last word carries a strobe that says whether the frame's checksum was good. Words are collected in a shadow store. A frame is copied into the active forecast, in a single cycle, only when it has the right length and a good checksum.

The actuation tick marks the instant the plant input is refreshed. If a good frame arrived since the previous tick, its current value is applied. Otherwise the block steps into the stored forecast by the number of ticks since that frame was applied. When the forecast runs out, the last applied value is held and an overrun mode is reported. Before the first good frame, the output follows a safe value input.

Top module: `ctrl_playback_buffer`

## Requirements
- R1: While reset is low and just after it, `ctrl_mode` is 0 (safe), `play_age` is 0 and `ctrl_out` equals `safe_value`.
- R2: Until a tick applies the first good frame, `ctrl_mode` stays 0 and `ctrl_out` follows `safe_value` in the same cycle, even across ticks.
- R3: A frame is exactly HORIZON+1 words. Word 0 is the current value and word i is the value forecast i ticks later. The frame is accepted only if its final word (marked by `pkt_last`) carries `pkt_crc_ok`=1 and is the (HORIZON+1)-th word since the previous final word.
- R4: A frame whose final word has `pkt_crc_ok`=0 changes neither the output nor the stored forecast.
- R5: A frame shorter or longer than HORIZON+1 words changes neither the output nor the stored forecast.
- R6: On the first tick after a frame is accepted, `ctrl_out` becomes that frame's word 0, `ctrl_mode` becomes 1 (fresh) and `play_age` becomes 0. These values are visible from the cycle after the tick.
- R7: On a tick with no newly accepted frame, `play_age` rises by one. If the new age a is at most HORIZON, `ctrl_out` becomes forecast word a and `ctrl_mode` becomes 2 (predicted).
- R8: `play_age` saturates at HORIZON+1. At that age `ctrl_mode` is 3 (overrun) and `ctrl_out` holds the last applied value until a good frame is applied.
- R9: A newly accepted frame replaces the whole stored forecast. If several frames are accepted between two ticks, the last one is used.
- R10: If a frame's final word is presented in the same cycle as a tick, that tick still uses the old state. The new frame is applied at the following tick.
- R11: `ctrl_mode`, `play_age` and, outside safe mode, `ctrl_out` change only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Frame word present this cycle |
| pkt_word | input | 16 | Frame word (control value) |
| pkt_last | input | 1 | Marks the final word of a frame |
| pkt_crc_ok | input | 1 | Checksum verdict, sampled with the final word |
| act_tick | input | 1 | Actuation instant, one-cycle pulse |
| safe_value | input | 16 | Output value used before the first good frame |
| ctrl_out | output | 16 | Control value applied to the plant |
| ctrl_mode | output | 2 | 0 safe, 1 fresh, 2 predicted, 3 overrun |
| play_age | output | 4 | Ticks since the last applied frame, saturating at HORIZON+1 |

## Verification
The bench builds the block with HORIZON=4. A frame is then five words, and overrun is reached five ticks after a fresh value. This brings saturation, hold and recovery within a few cycles, so the random phase passes through them many times. Because a frame is short, random ticks often fall on a final word or between two back-to-back frames, which exercises the same-cycle and last-wins orderings. Random frame lengths from 3 to 7 cover both too-short and too-long rejection.

// File: rtl/playback_pkg.sv
// Package: shared types of the predictive playback buffer.
// Assumes a 2-bit mode code that is visible at the top-level ports.
package playback_pkg;
    typedef enum logic [1:0] {
        MODE_SAFE    = 2'd0,
        MODE_FRESH   = 2'd1,
        MODE_PREDICT = 2'd2,
        MODE_OVERRUN = 2'd3
    } play_mode_e;
endpackage

// File: rtl/playback_frame_stage.sv
// Module: collects frame words into a shadow store and raises commit
// in the cycle of a final word that closes a well-formed, checksum-good frame.
// Assumes the final word itself is not stored here; the caller takes it directly.
module playback_frame_stage #(
    parameter int WORD_W  = 16,
    parameter int HORIZON = 9
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pkt_valid,
    input  logic [WORD_W-1:0]               pkt_word,
    input  logic                            pkt_last,
    input  logic                            pkt_crc_ok,
    output logic                            commit,
    output logic [HORIZON-1:0][WORD_W-1:0]  shadow
);
    localparam int IDX_W = $clog2(HORIZON + 2);
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(HORIZON);
    localparam logic [IDX_W-1:0] IDX_OVER = IDX_W'(HORIZON + 1);

    logic [IDX_W-1:0] idx_q;

    // Final word is accepted only at the exact length with a good checksum.
    assign commit = pkt_valid && pkt_last && pkt_crc_ok && (idx_q == IDX_FULL);

    // Word position counter; saturates once a frame is too long, clears on final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (pkt_valid) begin
            if (pkt_last)
                idx_q <= '0;
            else if (idx_q != IDX_OVER)
                idx_q <= idx_q + 1'b1;
        end
    end

    // One shadow register per leading word position.
    for (genvar i = 0; i < HORIZON; i++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[i] <= '0;
            else if (pkt_valid && !pkt_last && idx_q == IDX_W'(i))
                shadow[i] <= pkt_word;
        end
    end
endmodule

// File: rtl/playback_forecast_store.sv
// Module: active forecast, loaded as a whole in the commit cycle.
// Assumes commit is a single-cycle pulse that arrives with the final word.
module playback_forecast_store #(
    parameter int WORD_W  = 16,
    parameter int HORIZON = 9
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            commit,
    input  logic [HORIZON-1:0][WORD_W-1:0]  shadow,
    input  logic [WORD_W-1:0]               tail_word,
    output logic [HORIZON:0][WORD_W-1:0]    forecast
);
    // Leading entries come from the shadow store.
    for (genvar i = 0; i < HORIZON; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                forecast[i] <= '0;
            else if (commit)
                forecast[i] <= shadow[i];
        end
    end

    // Farthest prediction is the final word of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            forecast[HORIZON] <= '0;
        else if (commit)
            forecast[HORIZON] <= tail_word;
    end
endmodule

// File: rtl/playback_sequencer.sv
// Module: on each tick picks the fresh value, a forecast entry, or a hold.
// Assumes the forecast changes only in commit cycles; a commit in a tick
// cycle is seen by the next tick.
module playback_sequencer
    import playback_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int HORIZON = 9,
    parameter int AGE_W   = $clog2(HORIZON + 2)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic                          tick,
    input  logic [HORIZON:0][WORD_W-1:0]  forecast,
    output logic [WORD_W-1:0]             held,
    output play_mode_e                    mode,
    output logic [AGE_W-1:0]              age
);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(HORIZON + 1);

    logic               pending_q;
    logic [AGE_W-1:0]   age_next;
    logic [WORD_W-1:0]  pick;

    // Saturating next age.
    assign age_next = (age == AGE_MAX) ? age : age + 1'b1;

    // Forecast entry addressed by the next age.
    always_comb begin
        pick = '0;
        for (int i = 0; i <= HORIZON; i++)
            if (age_next == AGE_W'(i))
                pick = forecast[i];
    end

    // Remembers that an accepted frame waits for the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (commit)
            pending_q <= 1'b1;
        else if (tick)
            pending_q <= 1'b0;
    end

    // Applies a value at each tick and tracks age and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
            mode <= MODE_SAFE;
            age  <= '0;
        end else if (tick) begin
            if (pending_q) begin
                held <= forecast[0];
                mode <= MODE_FRESH;
                age  <= '0;
            end else if (mode != MODE_SAFE) begin
                age <= age_next;
                if (age_next != AGE_MAX) begin
                    held <= pick;
                    mode <= MODE_PREDICT;
                end else begin
                    mode <= MODE_OVERRUN;
                end
            end
        end
    end
endmodule

// File: rtl/ctrl_playback_buffer.sv
// Module: actuator-side playback buffer, the top level. It stages frames,
// commits good ones, and plays the current or forecast value at each tick.
// Assumes one tick per sample period and that frames end with pkt_last.
module ctrl_playback_buffer
    import playback_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int HORIZON = 9,
    parameter int AGE_W   = $clog2(HORIZON + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [WORD_W-1:0] pkt_word,
    input  logic              pkt_last,
    input  logic              pkt_crc_ok,
    input  logic              act_tick,
    input  logic [WORD_W-1:0] safe_value,
    output logic [WORD_W-1:0] ctrl_out,
    output logic [1:0]        ctrl_mode,
    output logic [AGE_W-1:0]  play_age
);
    logic                            commit;
    logic [HORIZON-1:0][WORD_W-1:0]  shadow;
    logic [HORIZON:0][WORD_W-1:0]    forecast;
    logic [WORD_W-1:0]               held;
    play_mode_e                      mode;

    playback_frame_stage #(.WORD_W(WORD_W), .HORIZON(HORIZON)) u_stage (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_word(pkt_word),
        .pkt_last(pkt_last), .pkt_crc_ok(pkt_crc_ok),
        .commit(commit), .shadow(shadow)
    );

    playback_forecast_store #(.WORD_W(WORD_W), .HORIZON(HORIZON)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .shadow(shadow),
        .tail_word(pkt_word), .forecast(forecast)
    );

    playback_sequencer #(.WORD_W(WORD_W), .HORIZON(HORIZON), .AGE_W(AGE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .commit(commit), .tick(act_tick),
        .forecast(forecast), .held(held), .mode(mode), .age(play_age)
    );

    // The safe value is shown until the first frame is applied.
    assign ctrl_out  = (mode == MODE_SAFE) ? safe_value : held;
    assign ctrl_mode = mode;
endmodule

// File: rtl/ctrl_playback_checker.sv
// Module: temporal checks on the playback buffer ports, bound to the top.
// Assumes mode codes 0 safe, 1 fresh, 2 predicted, 3 overrun.
module ctrl_playback_checker #(
    parameter int WORD_W  = 16,
    parameter int HORIZON = 9,
    parameter int AGE_W   = $clog2(HORIZON + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              act_tick,
    input logic [WORD_W-1:0] ctrl_out,
    input logic [1:0]        ctrl_mode,
    input logic [AGE_W-1:0]  play_age
);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(HORIZON + 1);

    assert_state_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !act_tick |=> $stable(ctrl_mode) && $stable(play_age));

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_tick && ctrl_mode != 2'd0) |=> $stable(ctrl_out));

    assert_age_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        play_age <= AGE_MAX);

    assert_overrun_age_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_mode == 2'd3 |-> play_age == AGE_MAX);

    assert_fresh_age_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_mode == 2'd1 |-> play_age == '0);

    assert_predict_age_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_mode == 2'd2 |-> (play_age != '0 && play_age < AGE_MAX));

    assert_safe_age_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_mode == 2'd0 |-> play_age == '0);
endmodule

bind ctrl_playback_buffer ctrl_playback_checker #(
    .WORD_W(WORD_W), .HORIZON(HORIZON), .AGE_W(AGE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .act_tick(act_tick), .ctrl_out(ctrl_out),
    .ctrl_mode(ctrl_mode), .play_age(play_age)
);

// File: tb/ctrl_playback_buffer_bench.sv
module ctrl_playback_buffer_bench;
    localparam int W  = 16;
    localparam int H  = 4;
    localparam int AW = $clog2(H + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0, pkt_last = 1'b0, pkt_crc_ok = 1'b0, act_tick = 1'b0;
    logic [W-1:0] pkt_word = '0, safe_value = 16'hA5A5;
    logic [W-1:0] ctrl_out;
    logic [1:0]   ctrl_mode;
    logic [AW-1:0] play_age;

    int checks = 0, errors = 0;
    bit finished = 0;

    // Bench model of the requirements.
    logic [W-1:0] m_fc [0:H];
    logic [W-1:0] m_sh [0:H-1];
    logic [W-1:0] m_out;
    int m_idx, m_age, m_mode;
    bit m_pending;
    logic [W-1:0] tx [0:7];

    always #4 clk = ~clk;

    ctrl_playback_buffer #(.WORD_W(W), .HORIZON(H)) u_ctrl_playback_buffer (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_word(pkt_word),
        .pkt_last(pkt_last), .pkt_crc_ok(pkt_crc_ok), .act_tick(act_tick),
        .safe_value(safe_value), .ctrl_out(ctrl_out), .ctrl_mode(ctrl_mode),
        .play_age(play_age)
    );

    function automatic string tag_for(int mode);
        case (mode)
            0: return "R2";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag);
        logic [W-1:0] exp_out;
        exp_out = (m_mode == 0) ? safe_value : m_out;
        checks++;
        if (ctrl_out !== exp_out || ctrl_mode !== 2'(m_mode) || play_age !== AW'(m_age)) begin
            errors++;
            $display("FAIL %s: out=%h mode=%0d age=%0d expected out=%h mode=%0d age=%0d",
                     tag, ctrl_out, ctrl_mode, play_age, exp_out, m_mode, m_age);
        end
    endtask

    // Model update for one clock edge, from the requirement rules.
    function automatic void model_edge(input bit v, input logic [W-1:0] w,
                                       input bit l, input bit ok, input bit t);
        bit commit;
        int na;
        commit = v && l && ok && (m_idx == H);
        if (t) begin
            if (m_pending) begin
                m_out = m_fc[0]; m_age = 0; m_mode = 1;
            end else if (m_mode != 0) begin
                na = (m_age == H + 1) ? m_age : m_age + 1;
                m_age = na;
                if (na <= H) begin m_out = m_fc[na]; m_mode = 2; end
                else m_mode = 3;
            end
        end
        if (commit) m_pending = 1;
        else if (t) m_pending = 0;
        if (commit) begin
            for (int i = 0; i < H; i++) m_fc[i] = m_sh[i];
            m_fc[H] = w;
        end
        if (v) begin
            if (l) m_idx = 0;
            else begin
                if (m_idx < H) m_sh[m_idx] = w;
                if (m_idx != H + 1) m_idx++;
            end
        end
    endfunction

    // One cycle: drive at the falling edge, check at the next falling edge.
    task automatic step(input bit v, input logic [W-1:0] w, input bit l,
                        input bit ok, input bit t, input string tag);
        pkt_valid = v; pkt_word = w; pkt_last = l; pkt_crc_ok = ok; act_tick = t;
        model_edge(v, w, l, ok, t);
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 0; pkt_last = 0; act_tick = 0;
        if (tag != "") check(tag);
        else if (!t) check("R11");
        else check(tag_for(m_mode));
    endtask

    // Sends n words from tx; the tick lands on beat tick_at (-1 for none).
    task automatic send(input int n, input bit ok, input int tick_at, input string tag);
        for (int i = 0; i < n; i++)
            step(1, tx[i], i == n - 1, ok, i == tick_at, tag);
    endtask

    task automatic fill(input logic [W-1:0] base);
        for (int i = 0; i < 8; i++) tx[i] = base + W'(i);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: out=%h mode=%0d age=%0d expected run to complete",
                     ctrl_out, ctrl_mode, play_age);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7341));
        for (int i = 0; i <= H; i++) m_fc[i] = '0;
        for (int i = 0; i < H; i++) m_sh[i] = '0;
        m_out = '0; m_idx = 0; m_age = 0; m_mode = 0; m_pending = 0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: ticks before any frame keep safe mode; output tracks safe_value.
        step(0, 0, 0, 0, 1, "R2");
        safe_value = 16'h1234;
        step(0, 0, 0, 0, 0, "R2");

        // R3/R6/R7/R8: full forecast playback, then overrun and hold.
        fill(16'd100);
        send(H + 1, 1, -1, "R3");
        step(0, 0, 0, 0, 1, "R6");
        for (int k = 1; k <= H; k++) step(0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 1, "R8");

        // R4: bad checksum frame is ignored.
        fill(16'd200);
        send(H + 1, 0, -1, "R4");
        step(0, 0, 0, 0, 1, "R4");

        // R5: short and long frames are ignored.
        fill(16'd250);
        send(H, 1, -1, "R5");
        step(0, 0, 0, 0, 1, "R5");
        send(H + 2, 1, -1, "R5");
        step(0, 0, 0, 0, 1, "R5");

        // R9: two frames before one tick, the last wins entirely.
        fill(16'd300);
        send(H + 1, 1, -1, "R9");
        fill(16'd400);
        send(H + 1, 1, -1, "R9");
        step(0, 0, 0, 0, 1, "R9");
        step(0, 0, 0, 0, 1, "R9");

        // R10: final word in the tick cycle is applied one tick later.
        fill(16'd500);
        send(H + 1, 1, H, "R10");
        step(0, 0, 0, 0, 1, "R10");

        // Random phase.
        for (int it = 0; it < 3000; it++) begin
            int r;
            r = $urandom % 10;
            if (r < 4) begin
                int n;
                bit ok;
                for (int i = 0; i < 8; i++) tx[i] = W'($urandom);
                n  = ($urandom % 5 == 0) ? 3 + int'($urandom % 5) : H + 1;
                ok = ($urandom % 8) != 0;
                for (int i = 0; i < n; i++)
                    step(1, tx[i], i == n - 1, ok, ($urandom % 4) == 0, "");
            end else begin
                if (($urandom % 16) == 0) safe_value = W'($urandom);
                step(0, 0, 0, 0, ($urandom % 2) == 0, "");
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule